// File: doc/BRIEF.md
# SPI Command Slave for a UART

This block sits between a host SPI master and a UART datapath. The host exchanges fixed 16-bit frames with it. The two most significant bits of each incoming frame pick one of four operations: write configuration, read configuration, write data or read data. While the host shifts a command in, the block shifts back two status flags, followed by either the stored configuration or the received byte.

Most effects are committed only when chip select rises after exactly sixteen SCLK rising edges. A frame that ends early or runs long is dropped. Interrupt mask bits are the exception: they take effect as soon as the sixteenth bit of a write-configuration frame is latched. The remaining configuration fields are held pending until the transmitter reports idle, and only then are they presented to the UART.

The SPI pins are sampled by the system clock through a synchronizer, so the SCLK rate must be well below the system clock. The UART datapath supplies the status flags and the received byte. It consumes the transmit and receive strobes, the configuration and the active-low interrupt.

Top module: `spi_uart_cmd`

## Requirements
- R1: Incoming bits are taken MSB first on SCLK rising edges. `miso_o` presents response bit 15 from the time chip select falls and moves to the next lower bit after each SCLK falling edge. `miso_o` is 0 while chip select is high.
- R2: Frame bits 15:14 encode the operation: 11 write configuration, 01 read configuration, 10 write data, 00 read data.
- R3: A frame with fewer or more than 16 SCLK rising edges before chip select rises commits nothing. It produces no strobe and leaves the readback, transmit data and RTS state unchanged.
- R4: In every operation, response bit 15 is `rx_valid_i` and bit 14 is `tx_empty_i`, both captured when chip select falls.
- R5: Write configuration stores frame bits 13:0 as the configuration word. Read configuration returns that word in response bits 13:0. The fields are: 13 FIFO disable, 12 shutdown, 11 transmit-empty mask, 10 receive-ready mask, 9 extra-bit mask, 8 framing mask, 7 infrared timing, 6 two stop bits, 5 extra bit enable, 4 short word, 3:0 baud divisor.
- R6: The mask bits 11:8 drive `mask_o` = {tx-empty, rx-ready, extra-bit, framing} once the 16th rising edge of a write-configuration frame is latched, before chip select rises.
- R7: The other configuration fields reach `cfg_o` = {13,12,7,6,5,4,3:0} only in a cycle where `tx_busy_i` is low. While `tx_busy_i` is high they stay pending.
- R8: A committed write configuration pulses `rx_clr_o` for one cycle and clears `tx_data_o` and `tx_xbit_o`. `rts_o` keeps its value.
- R9: Write data uses frame bits 7:0 as the byte, bit 8 as the extra bit, bit 9 as the RTS level and bit 10 as the write inhibit. A commit always updates `rts_o`. Without the inhibit it also loads `tx_data_o`/`tx_xbit_o` and pulses `tx_wr_o` once. With the inhibit it changes nothing else.
- R10: Read data returns response bits 7:0 from `rx_data_i`, bit 8 from `rx_xbit_i`, bit 9 from `cts_i` and bit 10 from `rx_flag_i`, with bits 13:11 zero. Its commit pulses `rx_rd_o` once only if the captured receive-ready flag was 1.
- R11: `irq_no` is low exactly when at least one of these flag/mask pairs has both members set: (`tx_empty_i`, tx-empty mask), (`rx_valid_i`, rx-ready mask), (`rx_xbit_i`, extra-bit mask), (`rx_flag_i`, framing mask).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI serial clock, idle low |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | SPI data from host |
| miso_o | output | 1 | SPI data to host |
| tx_busy_i | input | 1 | Transmitter is sending a character |
| tx_empty_i | input | 1 | Transmit buffer empty flag |
| rx_valid_i | input | 1 | Received data available flag |
| rx_data_i | input | 8 | Oldest received byte |
| rx_xbit_i | input | 1 | Extra bit stored with the received byte |
| rx_flag_i | input | 1 | Framing or receive-activity flag |
| cts_i | input | 1 | Clear-to-send level |
| cfg_o | output | 10 | Applied configuration fields |
| mask_o | output | 4 | Interrupt masks {tx-empty, rx-ready, extra-bit, framing} |
| tx_wr_o | output | 1 | One-cycle transmit write strobe |
| tx_data_o | output | 8 | Byte to transmit |
| tx_xbit_o | output | 1 | Extra bit to transmit |
| rts_o | output | 1 | RTS level |
| rx_rd_o | output | 1 | One-cycle receive pop strobe |
| rx_clr_o | output | 1 | One-cycle receive clear strobe |
| irq_no | output | 1 | Interrupt, active low |

## Verification
Each SPI pin edge reaches the logic three system clocks after it toggles: two synchronizer stages, then the edge detector. Masks are applied one cycle after a rising-edge detect. Strobes fire one cycle after the chip-select rise is detected, and pending configuration lands one cycle later when the transmitter is idle. The bench holds every SCLK phase and chip-select level for eight system clocks, so it samples `miso_o` at the rising edge and checks masks before raising chip select. It checks strobes, configuration and readback at least eight cycles after chip select rises. The interrupt is combinational, so the bench checks it one cycle after each flag change, and counts strobes on the falling clock edge.

// File: rtl/spi_uart_pkg.sv
package spi_uart_pkg;
  localparam int FRAME_W = 16;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam int LO_W    = FRAME_W - 2;

  typedef enum logic [1:0] {
    OP_RD_DATA = 2'b00,
    OP_RD_CFG  = 2'b01,
    OP_WR_DATA = 2'b10,
    OP_WR_CFG  = 2'b11
  } op_e;

  typedef struct packed {
    logic       fifo_off;
    logic       shdn;
    logic       irda;
    logic       two_stop;
    logic       xbit_en;
    logic       short_len;
    logic [3:0] baud;
  } uart_cfg_t;

  function automatic uart_cfg_t cfg_from_word(input logic [LO_W-1:0] w);
    uart_cfg_t c;
    c.fifo_off  = w[13];
    c.shdn      = w[12];
    c.irda      = w[7];
    c.two_stop  = w[6];
    c.xbit_en   = w[5];
    c.short_len = w[4];
    c.baud      = w[3:0];
    return c;
  endfunction
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic cs_active_o,
  output logic mosi_o
);
  logic [STAGES-1:0] sclk_s, cs_s, mosi_s;
  logic              sclk_q, cs_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sclk_s <= '0;
          cs_s   <= '1;
          mosi_s <= '0;
        end else begin
          sclk_s <= sclk_i;
          cs_s   <= cs_ni;
          mosi_s <= mosi_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sclk_s <= '0;
          cs_s   <= '1;
          mosi_s <= '0;
        end else begin
          sclk_s <= {sclk_s[STAGES-2:0], sclk_i};
          cs_s   <= {cs_s[STAGES-2:0], cs_ni};
          mosi_s <= {mosi_s[STAGES-2:0], mosi_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s[STAGES-1];
      cs_q   <= cs_s[STAGES-1];
    end
  end

  assign sclk_rise_o = sclk_s[STAGES-1] & ~sclk_q;
  assign sclk_fall_o = ~sclk_s[STAGES-1] & sclk_q;
  assign cs_fall_o   = ~cs_s[STAGES-1] & cs_q;
  assign cs_rise_o   = cs_s[STAGES-1] & ~cs_q;
  assign cs_active_o = ~cs_q;
  assign mosi_o      = mosi_s[STAGES-1];
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import spi_uart_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_rise_i,
  input  logic               sclk_fall_i,
  input  logic               cs_fall_i,
  input  logic               cs_rise_i,
  input  logic               cs_active_i,
  input  logic               mosi_i,
  input  logic [1:0]         stat_i,
  input  logic [LO_W-1:0]    resp_lo_i,
  output logic [FRAME_W-1:0] word_o,
  output logic               op_done_o,
  output logic               word_done_o,
  output logic               commit_o,
  output logic               stat_r_o,
  output logic               miso_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_W - 1);

  logic [CNT_W-1:0]   cnt_q;
  logic [IDX_W-1:0]   idx_q;
  logic [FRAME_W-1:0] word_q, resp_q;
  logic               op_done_q, word_done_q, commit_q;
  logic               rise_act, fall_act;

  assign rise_act = sclk_rise_i & cs_active_i;
  assign fall_act = sclk_fall_i & cs_active_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      idx_q       <= '0;
      word_q      <= '0;
      resp_q      <= '0;
      op_done_q   <= 1'b0;
      word_done_q <= 1'b0;
      commit_q    <= 1'b0;
    end else begin
      op_done_q   <= rise_act && cnt_q == CNT_W'(1);
      word_done_q <= rise_act && cnt_q == CNT_W'(FRAME_W - 1);
      commit_q    <= cs_rise_i && cnt_q == CNT_FULL;
      if (cs_fall_i) begin
        cnt_q  <= '0;
        idx_q  <= '0;
        word_q <= '0;
        resp_q <= {stat_i, {LO_W{1'b0}}};
      end else begin
        if (rise_act && cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
        if (rise_act && cnt_q < CNT_FULL) word_q <= {word_q[FRAME_W-2:0], mosi_i};
        if (fall_act && idx_q != IDX_LAST) idx_q <= idx_q + 1'b1;
        if (op_done_q) resp_q[LO_W-1:0] <= resp_lo_i;
      end
    end
  end

  assign word_o      = word_q;
  assign op_done_o   = op_done_q;
  assign word_done_o = word_done_q;
  assign commit_o    = commit_q;
  assign stat_r_o    = resp_q[FRAME_W-1];
  assign miso_o      = cs_active_i & resp_q[~idx_q];

  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_OVER);
  // R1: the output index never runs ahead of the latched input bits
  a_r1_idx_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_active_i && !cs_fall_i |-> CNT_W'(idx_q) <= cnt_q);
  a_r3_commit_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_q |-> $past(cnt_q) == CNT_FULL);
endmodule

// File: rtl/uart_cmd_regs.sv
module uart_cmd_regs
  import spi_uart_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FRAME_W-1:0] word_i,
  input  logic               word_done_i,
  input  logic               commit_i,
  input  logic               stat_r_i,
  input  logic               tx_busy_i,
  input  logic [7:0]         rx_data_i,
  input  logic               rx_xbit_i,
  input  logic               rx_flag_i,
  input  logic               cts_i,
  output logic [LO_W-1:0]    resp_lo_o,
  output uart_cfg_t          cfg_o,
  output logic [3:0]         mask_o,
  output logic               tx_wr_o,
  output logic [7:0]         tx_data_o,
  output logic               tx_xbit_o,
  output logic               rts_o,
  output logic               rx_rd_o,
  output logic               rx_clr_o
);
  op_e           op_early, op_full;
  logic [LO_W-1:0] cfg_word_q;
  uart_cfg_t     cfg_q, pend_q;
  logic          pend_vld_q;
  logic [3:0]    mask_q;
  logic          tx_wr_q, rx_rd_q, rx_clr_q, rts_q, tx_xbit_q;
  logic [7:0]    tx_data_q;

  assign op_early = op_e'(word_i[1:0]);
  assign op_full  = op_e'(word_i[FRAME_W-1:FRAME_W-2]);

  always_comb begin
    unique case (op_early)
      OP_RD_CFG:  resp_lo_o = cfg_word_q;
      OP_RD_DATA: resp_lo_o = {3'b000, rx_flag_i, cts_i, rx_xbit_i, rx_data_i};
      default:    resp_lo_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_word_q <= '0;
      cfg_q      <= '0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      mask_q     <= '0;
      tx_wr_q    <= 1'b0;
      rx_rd_q    <= 1'b0;
      rx_clr_q   <= 1'b0;
      rts_q      <= 1'b0;
      tx_xbit_q  <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      tx_wr_q  <= 1'b0;
      rx_rd_q  <= 1'b0;
      rx_clr_q <= 1'b0;
      if (word_done_i && op_full == OP_WR_CFG) mask_q <= word_i[11:8];
      if (pend_vld_q && !tx_busy_i) begin
        cfg_q      <= pend_q;
        pend_vld_q <= 1'b0;
      end
      if (commit_i) begin
        unique case (op_full)
          OP_WR_CFG: begin
            cfg_word_q <= word_i[LO_W-1:0];
            pend_q     <= cfg_from_word(word_i[LO_W-1:0]);
            pend_vld_q <= 1'b1;
            rx_clr_q   <= 1'b1;
            tx_data_q  <= '0;
            tx_xbit_q  <= 1'b0;
          end
          OP_WR_DATA: begin
            rts_q <= word_i[9];
            if (!word_i[10]) begin
              tx_data_q <= word_i[7:0];
              tx_xbit_q <= word_i[8];
              tx_wr_q   <= 1'b1;
            end
          end
          OP_RD_DATA: rx_rd_q <= stat_r_i;
          default: ;
        endcase
      end
    end
  end

  assign cfg_o     = cfg_q;
  assign mask_o    = mask_q;
  assign tx_wr_o   = tx_wr_q;
  assign tx_data_o = tx_data_q;
  assign tx_xbit_o = tx_xbit_q;
  assign rts_o     = rts_q;
  assign rx_rd_o   = rx_rd_q;
  assign rx_clr_o  = rx_clr_q;

  a_r7_cfg_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_q) |-> !$past(tx_busy_i));
  a_r9_wr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_q |=> !tx_wr_q);
  a_r8_clr_keeps_rts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_clr_q |-> $stable(rts_q));
  a_r10_rd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rd_q |=> !rx_rd_q);
endmodule

// File: rtl/spi_uart_cmd.sv
module spi_uart_cmd
  import spi_uart_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       cs_ni,
  input  logic       mosi_i,
  output logic       miso_o,
  input  logic       tx_busy_i,
  input  logic       tx_empty_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  input  logic       rx_xbit_i,
  input  logic       rx_flag_i,
  input  logic       cts_i,
  output logic [9:0] cfg_o,
  output logic [3:0] mask_o,
  output logic       tx_wr_o,
  output logic [7:0] tx_data_o,
  output logic       tx_xbit_o,
  output logic       rts_o,
  output logic       rx_rd_o,
  output logic       rx_clr_o,
  output logic       irq_no
);
  logic               sclk_rise, sclk_fall, cs_fall, cs_rise, cs_active, mosi_s;
  logic [FRAME_W-1:0] word;
  logic [LO_W-1:0]    resp_lo;
  logic               op_done, word_done, commit, stat_r;
  uart_cfg_t          cfg;
  logic [3:0]         mask;

  spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .mosi_i,
    .sclk_rise_o(sclk_rise), .sclk_fall_o(sclk_fall),
    .cs_fall_o(cs_fall), .cs_rise_o(cs_rise),
    .cs_active_o(cs_active), .mosi_o(mosi_s)
  );

  spi_frame_shifter u_shift (
    .clk_i, .rst_ni,
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
    .cs_fall_i(cs_fall), .cs_rise_i(cs_rise), .cs_active_i(cs_active),
    .mosi_i(mosi_s), .stat_i({rx_valid_i, tx_empty_i}), .resp_lo_i(resp_lo),
    .word_o(word), .op_done_o(op_done), .word_done_o(word_done),
    .commit_o(commit), .stat_r_o(stat_r), .miso_o
  );

  uart_cmd_regs u_regs (
    .clk_i, .rst_ni, .word_i(word), .word_done_i(word_done),
    .commit_i(commit), .stat_r_i(stat_r), .tx_busy_i,
    .rx_data_i, .rx_xbit_i, .rx_flag_i, .cts_i,
    .resp_lo_o(resp_lo), .cfg_o(cfg), .mask_o(mask),
    .tx_wr_o, .tx_data_o, .tx_xbit_o, .rts_o, .rx_rd_o, .rx_clr_o
  );

  assign cfg_o  = cfg;
  assign mask_o = mask;
  assign irq_no = ~|({tx_empty_i, rx_valid_i, rx_xbit_i, rx_flag_i} & mask);

  a_r11_no_mask_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask == 4'h0 |-> irq_no);
  a_r1_miso_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3) |-> !miso_o);
endmodule

// File: tb/tb_spi_uart_cmd.sv
module tb_spi_uart_cmd;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic tx_busy = 1'b0, tx_empty = 1'b1, rx_valid = 1'b0, rx_xbit = 1'b0;
  logic rx_flag = 1'b0, cts = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic miso, tx_wr, tx_xbit, rts, rx_rd, rx_clr, irq_n;
  logic [9:0] cfg;
  logic [3:0] mask;
  logic [7:0] tx_data;

  int n_chk = 0, n_err = 0, n_wr = 0, n_rd = 0, n_clr = 0;
  logic [15:0] r;

  always #2 clk = ~clk;

  spi_uart_cmd dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .tx_busy_i(tx_busy), .tx_empty_i(tx_empty),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_xbit_i(rx_xbit),
    .rx_flag_i(rx_flag), .cts_i(cts), .cfg_o(cfg), .mask_o(mask),
    .tx_wr_o(tx_wr), .tx_data_o(tx_data), .tx_xbit_o(tx_xbit), .rts_o(rts),
    .rx_rd_o(rx_rd), .rx_clr_o(rx_clr), .irq_no(irq_n)
  );

  always @(negedge clk) if (rst_n) begin
    if (tx_wr) n_wr++;
    if (rx_rd) n_rd++;
    if (rx_clr) n_clr++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic spi_bits(input logic [15:0] w, input int n, output logic [15:0] rd);
    rd = '0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      if (i < 16) rd[15-i] = miso;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic spi_end();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (HALF + 2) @(negedge clk);
  endtask

  task automatic xfer(input logic [15:0] w, output logic [15:0] rd);
    spi_bits(w, 16, rd);
    spi_end();
  endtask

  function automatic logic [9:0] cfg_of(input logic [15:0] w);
    return {w[13], w[12], w[7], w[6], w[5], w[4], w[3:0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] w, keep;
    int wr0, clr0, rd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state
    chk("R7 reset cfg", 32'(cfg), 0);
    chk("R6 reset mask", 32'(mask), 0);
    chk("R11 reset irq", 32'(irq_n), 1);
    chk("R1 miso idle", 32'(miso), 0);

    // R4 status bits, all four combinations, via read configuration (01)
    for (int s = 0; s < 4; s++) begin
      rx_valid = s[1]; tx_empty = s[0];
      xfer(16'h4000, r);
      chk("R4 status", 32'(r), 32'({s[1], s[0], 14'h0}));
    end
    rx_valid = 1'b0; tx_empty = 1'b1;

    // R6/R7 deferred configuration while busy
    tx_busy = 1'b1;
    w = 16'hC000 | 16'h2A00 | 16'h00B5;
    clr0 = n_clr;
    spi_bits(w, 16, r);
    chk("R6 mask before cs rise", 32'(mask), 32'(w[11:8]));
    spi_end();
    repeat (8) @(negedge clk);
    chk("R7 cfg held while busy", 32'(cfg), 0);
    chk("R8 clear strobe", n_clr - clr0, 1);
    tx_busy = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 cfg applied when idle", 32'(cfg), 32'(cfg_of(w)));
    xfer(16'h4000, r);
    chk("R5 readback", 32'(r[13:0]), 32'(w[13:0]));

    // R5/R2 sweep of configuration words
    for (int b = 0; b < 16; b++) begin
      logic [3:0] bb;
      bb = 4'(b);
      w = {2'b11, bb[1:0], bb, ~bb, bb ^ 4'h9};
      xfer(w, r);
      repeat (3) @(negedge clk);
      chk("R7 cfg sweep", 32'(cfg), 32'(cfg_of(w)));
      chk("R6 mask sweep", 32'(mask), 32'(w[11:8]));
      xfer(16'h4000, r);
      chk("R5 readback sweep", 32'(r), 32'({2'b01, w[13:0]}));
    end
    keep = w;

    // R3 short and long frames commit nothing
    clr0 = n_clr; wr0 = n_wr;
    spi_bits(16'hC123, 8, r); spi_end();
    spi_bits(16'h87FF, 17, r); spi_end();
    xfer(16'h4000, r);
    chk("R3 short frame readback", 32'(r[13:0]), 32'(keep[13:0]));
    spi_bits({2'b11, keep[13:0]} ^ 16'h00FF, 17, r); spi_end();
    xfer(16'h4000, r);
    chk("R3 long frame readback", 32'(r[13:0]), 32'(keep[13:0]));
    chk("R3 no clear strobe", n_clr - clr0, 0);
    chk("R3 no write strobe", n_wr - wr0, 0);
    chk("R3 rts unchanged", 32'(rts), 0);

    // R9 write data (10)
    wr0 = n_wr;
    xfer({2'b10, 3'b000, 1'b0, 1'b1, 1'b1, 8'h3C}, r);
    chk("R9 write strobe", n_wr - wr0, 1);
    chk("R9 tx data", 32'(tx_data), 32'h3C);
    chk("R9 tx extra bit", 32'(tx_xbit), 1);
    chk("R9 rts set", 32'(rts), 1);
    xfer({2'b10, 3'b000, 1'b1, 1'b0, 1'b0, 8'hFF}, r);
    chk("R9 inhibit no strobe", n_wr - wr0, 1);
    chk("R9 inhibit keeps data", 32'(tx_data), 32'h3C);
    chk("R9 inhibit rts clear", 32'(rts), 0);
    xfer({2'b10, 3'b000, 1'b1, 1'b1, 1'b0, 8'h00}, r);
    chk("R9 inhibit rts set", 32'(rts), 1);

    // R8 write configuration clears transmit data, keeps rts
    xfer(16'hC000, r);
    chk("R8 tx data cleared", 32'(tx_data), 0);
    chk("R8 tx extra bit cleared", 32'(tx_xbit), 0);
    chk("R8 rts kept", 32'(rts), 1);

    // R10 read data (00)
    rd0 = n_rd;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] d;
      d = 8'hA5 ^ 8'(k * 37);
      rx_valid = 1'b1; rx_data = d; rx_xbit = k[0]; rx_flag = k[1]; cts = ~k[0];
      tx_empty = k[1];
      xfer(16'h0000, r);
      chk("R10 read data response", 32'(r),
          32'({1'b1, k[1], 3'b000, k[1], ~k[0], k[0], d}));
    end
    chk("R10 pop strobes", n_rd - rd0, 4);
    rx_valid = 1'b0;
    xfer(16'h0000, r);
    chk("R10 no pop when empty", n_rd - rd0, 4);
    rx_xbit = 1'b0; rx_flag = 1'b0; tx_empty = 1'b0;

    // R11 interrupt over every mask and flag combination
    for (int m = 0; m < 16; m++) begin
      xfer({2'b11, 2'b00, 4'(m), 8'h00}, r);
      for (int f = 0; f < 16; f++) begin
        logic [3:0] ff;
        ff = 4'(f);
        tx_empty = ff[3]; rx_valid = ff[2]; rx_xbit = ff[1]; rx_flag = ff[0];
        @(negedge clk);
        chk("R11 irq", 32'(irq_n), 32'(~|(ff & 4'(m))));
      end
      tx_empty = 1'b0; rx_valid = 1'b0; rx_xbit = 1'b0; rx_flag = 1'b0;
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule